// File: doc/BRIEF.md
# Three-Product Complex Multiplier

This block multiplies two complex numbers whose real and imaginary parts are signed two's complement values of N bits (default 8). It forms the real part ar·br − ai·bi and the imaginary part ar·bi + ai·br. It does this with three real multiplications instead of four, spending a few extra adders on the way in and on the way out. A pre-add stage forms three widened sums and differences of the operand parts. Three signed radix-4 Booth multipliers each form one shared product. A post-combine stage subtracts or adds those products into the two results.

Each result is 2N+2 bits wide, which holds every possible outcome exactly, the all-most-negative case included. By default the results pass through a register with a synchronous reset. That register loads only in a cycle where the valid strobe is high, and a valid flag marks the cycle that follows. When the register is switched off by parameter, the block is purely combinational and the valid flag follows the strobe directly. The block has no state machine. Its only sequential element is the optional register, which has two conditions: reset, and load on strobe.

Top module: `cmul3`

## Requirements
- R1: With the strobe high at a rising edge, the real output after that edge equals ar·br − ai·bi of the sampled operands, as an exact signed value in 2N+2 bits.
- R2: With the strobe high at a rising edge, the imaginary output after that edge equals ar·bi + ai·br of the sampled operands, as an exact signed value in 2N+2 bits.
- R3: Operands equal to the most negative value −2^(N−1), in any combination, give exact results with no wrap. With all four at −128 (N=8), the real output is 0 and the imaginary output is +32768.
- R4: The output valid flag is high in the cycle after every edge that samples the strobe high, and low in the cycle after every edge that samples it low. Back-to-back strobes give back-to-back results.
- R5: While the strobe is low, changes on the operand inputs have no effect: both results keep the values from the last strobed operation.
- R6: The reset is synchronous and active high. A rising edge with reset high clears both results and the valid flag to zero, even when the strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Operand strobe; results load when high |
| a_re | input | N | Real part of the first operand, signed |
| a_im | input | N | Imaginary part of the first operand, signed |
| b_re | input | N | Real part of the second operand, signed |
| b_im | input | N | Imaginary part of the second operand, signed |
| res_re | output | 2N+2 | Real part of the product, signed |
| res_im | output | 2N+2 | Imaginary part of the product, signed |
| res_vld | output | 1 | High in the cycle after a strobed operation |

## Verification
Both results and the valid flag are due exactly one rising edge after the edge that samples the strobe high. The bench drives operands and the strobe on the falling edge. It reads res_re, res_im and res_vld on the next falling edge, half a period after the capturing edge, so every result is compared in the cycle it belongs to. Expected values come from the direct four-product formula, computed in bench functions on plain integers. Hold checks let several cycles pass with the strobe low and the operands changed before reading the outputs, and the reset check raises reset while the strobe is still high.

// File: rtl/cmul_pkg.sv
`timescale 1ns/1ps
package cmul_pkg;

    // magnitude picked by one radix-4 Booth digit
    typedef enum logic [1:0] {
        MAG_ZERO = 2'd0,
        MAG_ONE  = 2'd1,
        MAG_TWO  = 2'd2
    } booth_mag_e;

    // triplet = {b[2i+1], b[2i], b[2i-1]}; digit = -2*t[2] + t[1] + t[0]
    function automatic booth_mag_e booth_mag(input logic [2:0] t);
        booth_mag_e m;
        unique case (t)
            3'b001, 3'b010, 3'b101, 3'b110: m = MAG_ONE;
            3'b011, 3'b100:                 m = MAG_TWO;
            default:                        m = MAG_ZERO;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/cmul_booth_mul.sv
`timescale 1ns/1ps
module cmul_booth_mul
    import cmul_pkg::*;
#(
    parameter int WA = 8,
    parameter int WB = 9
) (
    input  logic signed [WA-1:0]    a,
    input  logic signed [WB-1:0]    b,
    output logic signed [WA+WB-1:0] p
);
    localparam int WP  = WA + WB;
    localparam int WBE = WB + 2 - (WB % 2);   // even, at least one sign bit added
    localparam int NG  = WBE / 2;

    logic [WBE:0]           bx;               // bx[0] is the implied zero below the LSB
    logic signed [WP-1:0]   a_ext;
    logic signed [WP-1:0]   pp [NG];

    assign bx    = {{(WBE-WB){b[WB-1]}}, b, 1'b0};
    assign a_ext = {{(WP-WA){a[WA-1]}}, a};

    for (genvar g = 0; g < NG; g++) begin : g_pp
        logic [2:0]           trip;
        booth_mag_e           sel;
        logic signed [WP-1:0] mag;

        assign trip = bx[2*g+2 : 2*g];
        assign sel  = booth_mag(trip);

        always_comb begin
            unique case (sel)
                MAG_ONE: mag = a_ext;
                MAG_TWO: mag = a_ext <<< 1;
                default: mag = '0;
            endcase
        end

        assign pp[g] = (trip[2] ? -mag : mag) <<< (2*g);
    end

    always_comb begin
        logic signed [WP-1:0] acc;
        acc = '0;
        for (int i = 0; i < NG; i++) begin
            acc = acc + pp[i];
        end
        p = acc;
    end

endmodule

// File: rtl/cmul_preadd.sv
`timescale 1ns/1ps
module cmul_preadd #(
    parameter int N = 8
) (
    input  logic signed [N-1:0] a_re,
    input  logic signed [N-1:0] a_im,
    input  logic signed [N-1:0] b_re,
    input  logic signed [N-1:0] b_im,
    output logic signed [N:0]   a_sum,     // a_re + a_im
    output logic signed [N:0]   b_dif,     // b_im - b_re
    output logic signed [N:0]   b_sum      // b_re + b_im
);
    logic signed [N:0] ar_x, ai_x, br_x, bi_x;

    assign ar_x  = {a_re[N-1], a_re};
    assign ai_x  = {a_im[N-1], a_im};
    assign br_x  = {b_re[N-1], b_re};
    assign bi_x  = {b_im[N-1], b_im};

    assign a_sum = ar_x + ai_x;
    assign b_dif = bi_x - br_x;
    assign b_sum = br_x + bi_x;

endmodule

// File: rtl/cmul_post.sv
`timescale 1ns/1ps
module cmul_post #(
    parameter int N = 8
) (
    input  logic signed [2*N:0]   k1,
    input  logic signed [2*N:0]   k2,
    input  logic signed [2*N:0]   k3,
    output logic signed [2*N+1:0] re,
    output logic signed [2*N+1:0] im
);
    logic signed [2*N+1:0] k1_x, k2_x, k3_x;

    assign k1_x = {k1[2*N], k1};
    assign k2_x = {k2[2*N], k2};
    assign k3_x = {k3[2*N], k3};

    assign re = k1_x - k3_x;
    assign im = k1_x + k2_x;

endmodule

// File: rtl/cmul3.sv
`timescale 1ns/1ps
module cmul3 #(
    parameter int N       = 8,
    parameter bit REG_OUT = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_vld,
    input  logic signed [N-1:0]   a_re,
    input  logic signed [N-1:0]   a_im,
    input  logic signed [N-1:0]   b_re,
    input  logic signed [N-1:0]   b_im,
    output logic signed [2*N+1:0] res_re,
    output logic signed [2*N+1:0] res_im,
    output logic                  res_vld
);
    localparam int SW = N + 1;       // pre-adder width
    localparam int KW = 2 * N + 1;   // product width
    localparam int RW = 2 * N + 2;   // result width

    logic signed [SW-1:0] a_sum, b_dif, b_sum;
    logic signed [KW-1:0] k1, k2, k3;
    logic signed [RW-1:0] nxt_re, nxt_im;

    cmul_preadd #(.N(N)) u_pre (
        .a_re  (a_re),
        .a_im  (a_im),
        .b_re  (b_re),
        .b_im  (b_im),
        .a_sum (a_sum),
        .b_dif (b_dif),
        .b_sum (b_sum)
    );

    // k1 = b_re * (a_re + a_im)
    cmul_booth_mul #(.WA(N), .WB(SW)) u_k1 (.a(b_re), .b(a_sum), .p(k1));
    // k2 = a_re * (b_im - b_re)
    cmul_booth_mul #(.WA(N), .WB(SW)) u_k2 (.a(a_re), .b(b_dif), .p(k2));
    // k3 = a_im * (b_re + b_im)
    cmul_booth_mul #(.WA(N), .WB(SW)) u_k3 (.a(a_im), .b(b_sum), .p(k3));

    cmul_post #(.N(N)) u_post (
        .k1 (k1),
        .k2 (k2),
        .k3 (k3),
        .re (nxt_re),
        .im (nxt_im)
    );

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                res_re  <= '0;
                res_im  <= '0;
                res_vld <= 1'b0;
            end else begin
                res_vld <= in_vld;
                if (in_vld) begin
                    res_re <= nxt_re;
                    res_im <= nxt_im;
                end
            end
        end
    end else begin : g_comb
        assign res_re  = nxt_re;
        assign res_im  = nxt_im;
        assign res_vld = in_vld;
    end

endmodule

// File: rtl/cmul3_chk.sv
`timescale 1ns/1ps
module cmul3_chk #(
    parameter int N       = 8,
    parameter bit REG_OUT = 1'b1
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  in_vld,
    input logic signed [N-1:0]   a_re,
    input logic signed [N-1:0]   a_im,
    input logic signed [N-1:0]   b_re,
    input logic signed [N-1:0]   b_im,
    input logic signed [2*N+1:0] res_re,
    input logic signed [2*N+1:0] res_im,
    input logic                  res_vld
);
    localparam int RW = 2 * N + 2;

    // direct four-product reference from the ports
    logic signed [RW-1:0] ref_re, ref_im;
    assign ref_re = RW'(a_re) * RW'(b_re) - RW'(a_im) * RW'(b_im);
    assign ref_im = RW'(a_re) * RW'(b_im) + RW'(a_im) * RW'(b_re);

    if (REG_OUT) begin : g_seq
        logic rst_q = 1'b0;

        always_ff @(posedge clk) begin
            rst_q <= rst;
            // R6
            if (rst_q) begin
                reset_clear_chk: assert (res_re == '0 && res_im == '0 && !res_vld)
                    else $error("outputs not cleared by reset");
            end
        end

        // R1
        real_value_chk: assert property (@(posedge clk) disable iff (rst)
            in_vld |=> (res_re == $past(ref_re)));

        // R2
        imag_value_chk: assert property (@(posedge clk) disable iff (rst)
            in_vld |=> (res_im == $past(ref_im)));

        // R4
        valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
            in_vld |=> res_vld);

        // R4
        valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
            !in_vld |=> !res_vld);

        // R5
        hold_chk: assert property (@(posedge clk) disable iff (rst)
            !in_vld |=> ($stable(res_re) && $stable(res_im)));
    end else begin : g_cmb
        always @(negedge clk) begin
            // R1
            if (in_vld) begin
                comb_value_chk: assert (res_re == ref_re && res_im == ref_im)
                    else $error("combinational result mismatch");
            end
        end
    end

endmodule

bind cmul3 cmul3_chk #(.N(N), .REG_OUT(REG_OUT)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .in_vld  (in_vld),
    .a_re    (a_re),
    .a_im    (a_im),
    .b_re    (b_re),
    .b_im    (b_im),
    .res_re  (res_re),
    .res_im  (res_im),
    .res_vld (res_vld)
);

// File: tb/cmul3_tb.sv
`timescale 1ns/1ps
module cmul3_tb;
    localparam int N  = 8;
    localparam int RW = 2 * N + 2;
    localparam int MAXCYC = 200000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_vld = 1'b0;
    logic signed [N-1:0]  a_re = '0, a_im = '0, b_re = '0, b_im = '0;
    logic signed [RW-1:0] res_re, res_im;
    logic                 res_vld;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    cmul3 #(.N(N), .REG_OUT(1'b1)) u_dut (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (in_vld),
        .a_re    (a_re),
        .a_im    (a_im),
        .b_re    (b_re),
        .b_im    (b_im),
        .res_re  (res_re),
        .res_im  (res_im),
        .res_vld (res_vld)
    );

    function automatic longint exp_re(int ar, int ai, int br, int bi);
        return longint'(ar) * br - longint'(ai) * bi;
    endfunction

    function automatic longint exp_im(int ar, int ai, int br, int bi);
        return longint'(ar) * bi + longint'(ai) * br;
    endfunction

    task automatic chk(input string req, input longint got, input longint exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, got, exp);
        end
    endtask

    int last_ar, last_ai, last_br, last_bi;

    // called right after a falling edge; result read on the next falling edge
    task automatic issue(input int ar, input int ai, input int br, input int bi,
                         input string tag);
        a_re = N'(ar); a_im = N'(ai); b_re = N'(br); b_im = N'(bi);
        in_vld = 1'b1;
        @(negedge clk);
        last_ar = ar; last_ai = ai; last_br = br; last_bi = bi;
        chk({tag, " R1 real"}, longint'(res_re), exp_re(ar, ai, br, bi));
        chk({tag, " R2 imag"}, longint'(res_im), exp_im(ar, ai, br, bi));
        chk({tag, " R4 valid high"}, longint'(res_vld), 1);
    endtask

    function automatic int rnd_op();
        return int'($signed(8'($urandom())));
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R6: state while held in reset
        chk("R6 reset re", longint'(res_re), 0);
        chk("R6 reset im", longint'(res_im), 0);
        chk("R6 reset vld", longint'(res_vld), 0);
        rst = 1'b0;
        @(negedge clk);

        // R3: most negative values and other corners
        issue(-128, -128, -128, -128, "R3 all-min");
        in_vld = 1'b0; @(negedge clk);
        chk("R4 valid low after idle", longint'(res_vld), 0);
        issue(127, 127, 127, 127, "R3 all-max");
        issue(-128, 127, -128, 127, "R3 mixed");
        issue(127, -128, -128, 127, "R3 mixed2");
        issue(-128, 0, -128, 0, "R3 real-min");
        issue(0, -128, 0, -128, "R3 imag-min");
        issue(-128, -128, 127, 127, "R3 cross");
        issue(0, 0, 0, 0, "R1 zero");
        issue(1, 0, 0, 1, "R2 unit");
        issue(3, -5, -7, 2, "R1 small");

        // random, back-to-back and with gaps
        for (int i = 0; i < 300; i++) begin
            issue(rnd_op(), rnd_op(), rnd_op(), rnd_op(), "R1R2 rand");
            if ($urandom() % 4 == 0) begin
                in_vld = 1'b0;
                @(negedge clk);
                chk("R4 valid low in gap", longint'(res_vld), 0);
            end
        end

        // R5: operands change with the strobe low
        in_vld = 1'b0;
        for (int j = 0; j < 4; j++) begin
            a_re = N'(rnd_op()); a_im = N'(rnd_op());
            b_re = N'(rnd_op()); b_im = N'(rnd_op());
            @(negedge clk);
        end
        chk("R5 hold re", longint'(res_re), exp_re(last_ar, last_ai, last_br, last_bi));
        chk("R5 hold im", longint'(res_im), exp_im(last_ar, last_ai, last_br, last_bi));
        chk("R5 hold vld", longint'(res_vld), 0);

        // R6: reset wins over a strobe
        issue(100, -50, 25, -75, "R1 pre-reset");
        a_re = 8'sd9; a_im = 8'sd9; b_re = 8'sd9; b_im = 8'sd9;
        in_vld = 1'b1;
        rst    = 1'b1;
        @(negedge clk);
        chk("R6 mid re", longint'(res_re), 0);
        chk("R6 mid im", longint'(res_im), 0);
        chk("R6 mid vld", longint'(res_vld), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after reset", longint'(res_re), 0);
        chk("R2 after reset", longint'(res_im), 162);
        in_vld = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (MAXCYC) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule